// File: doc/BRIEF.md
# Sized Arithmetic and Logic Unit with Condition Flags

This block is the integer execution stage of a small processor core. Every clock it can take one operation on two operands that are already fetched: the first operand (`opnd_a`) is the destination value and the second (`opnd_b`) is the source. It works at byte, word or long width. The result is zero-extended to the full data width and stored in a result register. The four arithmetic flags are stored in an 8-bit flag register.

Each operation class has its own rule for the overflow and carry flags. Software can also change the flag register directly: it can AND, OR or XOR it with an 8-bit immediate, or load it outright. A condition evaluator reads the stored flags and answers, for any of sixteen branch conditions, whether a conditional branch would be taken.

The flag register layout, from bit 7 down to bit 0, is: interrupt mask, user bit, half carry, user bit, negative (N), zero (Z), overflow (V), carry (C). Arithmetic and logic operations touch only bits 3..0.

Top module: `ccr_alu`

## Requirements
- R1: A synchronous active-high reset clears the result register to 0 and sets the flag register to 8'h80.
- R2: Opcode 0 adds and opcode 4 adds plus the stored C. C is the carry out of the top bit at the selected size. V is set when both operands have the same sign and the result sign differs from it.
- R3: Opcode 1 subtracts (a-b), opcode 2 compares, and opcode 5 subtracts b and the stored C. C is the borrow. V is set when the operand signs differ and the result sign differs from a. A compare updates the flags but leaves the result register unchanged.
- R4: Opcode 3 negates (0-a). V is set only when a is the most negative value at the selected size, and C is set when a is nonzero.
- R5: Opcode 6 increments a by one and opcode 7 decrements a by one. For an increment, V is set when a is the largest positive value; for a decrement, V is set when a is the most negative value. C is left unchanged.
- R6: Opcodes 8, 9 and 10 give a AND b, a OR b and a XOR b, and opcode 11 moves b. These set N and Z, clear V and leave C unchanged.
- R7: The size code is 0 for byte, 1 for word and 2 for long; code 3 acts as long. The result is zero-extended above the selected size. N is the top bit of the result at that size, and Z is set exactly when the result at that size is zero.
- R8: When `ccr_wr_en` is high, the flag register becomes itself AND the immediate (function 0), OR it (1), XOR it (2), or the immediate alone (3). This write wins over any flag update from an operation in the same cycle, while that operation still writes its result.
- R9: No operation changes flag bits 7..4.
- R10: Opcodes 12 to 15 change neither the result register nor the flag register.
- R11: `cond_true` is combinational on `cond_sel` and the stored flags. The conditions are: 0 always; 1 never; 2 !(C|Z); 3 C|Z; 4 !C; 5 C; 6 !Z; 7 Z; 8 !V; 9 V; 10 !N; 11 N; 12 !(N^V); 13 N^V; 14 !(Z|(N^V)); 15 Z|(N^V).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Execute `op_code` this cycle |
| op_code | input | 4 | Operation select |
| op_size | input | 2 | Operand size select |
| opnd_a | input | DW | First operand (destination value) |
| opnd_b | input | DW | Second operand (source value) |
| ccr_wr_en | input | 1 | Immediate write to the flag register |
| ccr_wr_fn | input | 2 | Immediate write function |
| ccr_imm | input | 8 | Immediate for the flag write |
| cond_sel | input | 4 | Branch condition select |
| result_q | output | DW | Registered result, zero-extended |
| ccr_q | output | 8 | Registered flag register |
| cond_true | output | 1 | Selected branch condition holds |

## Verification
The assertions take for granted that `op_code`, `op_size` and `ccr_wr_fn` carry known values whenever `op_valid` or `ccr_wr_en` is high. They also take for granted that the flag and result registers are observed only one edge after a request. The bench drives every input at the falling clock edge and drops `op_valid` and `ccr_wr_en` after a single cycle. Before each table entry, it loads the flag register with a known upper nibble and a chosen carry, so the carry-in and the kept bits are always defined.

// File: rtl/ccr_alu_pkg.sv
package ccr_alu_pkg;

  // operation codes
  localparam logic [3:0] OPC_ADD  = 4'd0;
  localparam logic [3:0] OPC_SUB  = 4'd1;
  localparam logic [3:0] OPC_CMP  = 4'd2;
  localparam logic [3:0] OPC_NEG  = 4'd3;
  localparam logic [3:0] OPC_ADDX = 4'd4;
  localparam logic [3:0] OPC_SUBX = 4'd5;
  localparam logic [3:0] OPC_INC  = 4'd6;
  localparam logic [3:0] OPC_DEC  = 4'd7;
  localparam logic [3:0] OPC_AND  = 4'd8;
  localparam logic [3:0] OPC_OR   = 4'd9;
  localparam logic [3:0] OPC_XOR  = 4'd10;
  localparam logic [3:0] OPC_MOV  = 4'd11;

  // flag bit positions
  localparam int CCR_C = 0;
  localparam int CCR_V = 1;
  localparam int CCR_Z = 2;
  localparam int CCR_N = 3;

  // immediate flag write functions
  localparam logic [1:0] CW_AND  = 2'd0;
  localparam logic [1:0] CW_OR   = 2'd1;
  localparam logic [1:0] CW_XOR  = 2'd2;
  localparam logic [1:0] CW_LOAD = 2'd3;

  // flag update classes
  typedef enum logic [1:0] {
    FC_NONE  = 2'd0,
    FC_ARITH = 2'd1,
    FC_STEP  = 2'd2,
    FC_LOGIC = 2'd3
  } fclass_e;

  function automatic fclass_e op_class(logic [3:0] op);
    if (op <= OPC_SUBX)      return FC_ARITH;
    else if (op <= OPC_DEC)  return FC_STEP;
    else if (op <= OPC_MOV)  return FC_LOGIC;
    else                     return FC_NONE;
  endfunction

  function automatic logic op_writes(logic [3:0] op);
    return (op <= OPC_MOV) && (op != OPC_CMP);
  endfunction

endpackage

// File: rtl/ccr_alu_lane.sv
module ccr_alu_lane
  import ccr_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         fl_n,
  output logic         fl_z,
  output logic         fl_v,
  output logic         fl_c
);

  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] ONE  = W'(1);

  logic [W:0] wide;
  logic       cx;

  always_comb begin
    wide = '0;
    res  = a;
    fl_v = 1'b0;
    fl_c = 1'b0;
    cx   = ((op == OPC_ADDX) || (op == OPC_SUBX)) ? cin : 1'b0;
    case (op)
      OPC_ADD, OPC_ADDX: begin
        wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cx};
        res  = wide[W-1:0];
        fl_c = wide[W];
        fl_v = (a[W-1] == b[W-1]) && (res[W-1] != a[W-1]);
      end
      OPC_SUB, OPC_CMP, OPC_SUBX: begin
        wide = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cx};
        res  = wide[W-1:0];
        fl_c = wide[W];
        fl_v = (a[W-1] != b[W-1]) && (res[W-1] != a[W-1]);
      end
      OPC_NEG: begin
        wide = {(W+1){1'b0}} - {1'b0, a};
        res  = wide[W-1:0];
        fl_c = wide[W];
        fl_v = (a == SMIN);
      end
      OPC_INC: begin
        res  = a + ONE;
        fl_v = (a == SMAX);
      end
      OPC_DEC: begin
        res  = a - ONE;
        fl_v = (a == SMIN);
      end
      OPC_AND: res = a & b;
      OPC_OR:  res = a | b;
      OPC_XOR: res = a ^ b;
      OPC_MOV: res = b;
      default: res = a;
    endcase
    fl_n = res[W-1];
    fl_z = (res == '0);
  end

endmodule

// File: rtl/ccr_alu_flagmerge.sv
module ccr_alu_flagmerge
  import ccr_alu_pkg::*;
(
  input  logic [7:0] ccr_cur,
  input  logic       alu_go,
  input  fclass_e    fclass,
  input  logic       fn,
  input  logic       fz,
  input  logic       fv,
  input  logic       fc,
  input  logic       wr_en,
  input  logic [1:0] wr_fn,
  input  logic [7:0] imm,
  output logic [7:0] ccr_nxt
);

  always_comb begin
    ccr_nxt = ccr_cur;
    if (wr_en) begin
      case (wr_fn)
        CW_AND:  ccr_nxt = ccr_cur & imm;
        CW_OR:   ccr_nxt = ccr_cur | imm;
        CW_XOR:  ccr_nxt = ccr_cur ^ imm;
        default: ccr_nxt = imm;
      endcase
    end else if (alu_go) begin
      case (fclass)
        FC_ARITH: begin
          ccr_nxt[CCR_N] = fn;
          ccr_nxt[CCR_Z] = fz;
          ccr_nxt[CCR_V] = fv;
          ccr_nxt[CCR_C] = fc;
        end
        FC_STEP: begin
          ccr_nxt[CCR_N] = fn;
          ccr_nxt[CCR_Z] = fz;
          ccr_nxt[CCR_V] = fv;
        end
        FC_LOGIC: begin
          ccr_nxt[CCR_N] = fn;
          ccr_nxt[CCR_Z] = fz;
          ccr_nxt[CCR_V] = 1'b0;
        end
        default: ccr_nxt = ccr_cur;
      endcase
    end
  end

endmodule

// File: rtl/ccr_alu_cond.sv
module ccr_alu_cond
  import ccr_alu_pkg::*;
(
  input  logic [3:0] flags,
  input  logic [3:0] sel,
  output logic       take
);

  logic n, z, v, c, lt;

  always_comb begin
    n  = flags[CCR_N];
    z  = flags[CCR_Z];
    v  = flags[CCR_V];
    c  = flags[CCR_C];
    lt = n ^ v;
    case (sel)
      4'd0:    take = 1'b1;
      4'd1:    take = 1'b0;
      4'd2:    take = !(c | z);
      4'd3:    take = c | z;
      4'd4:    take = !c;
      4'd5:    take = c;
      4'd6:    take = !z;
      4'd7:    take = z;
      4'd8:    take = !v;
      4'd9:    take = v;
      4'd10:   take = !n;
      4'd11:   take = n;
      4'd12:   take = !lt;
      4'd13:   take = lt;
      4'd14:   take = !(z | lt);
      default: take = z | lt;
    endcase
  end

endmodule

// File: rtl/ccr_alu.sv
module ccr_alu
  import ccr_alu_pkg::*;
#(
  parameter int         DW      = 32,
  parameter logic [7:0] CCR_RST = 8'h80
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_valid,
  input  logic [3:0]    op_code,
  input  logic [1:0]    op_size,
  input  logic [DW-1:0] opnd_a,
  input  logic [DW-1:0] opnd_b,
  input  logic          ccr_wr_en,
  input  logic [1:0]    ccr_wr_fn,
  input  logic [7:0]    ccr_imm,
  input  logic [3:0]    cond_sel,
  output logic [DW-1:0] result_q,
  output logic [7:0]    ccr_q,
  output logic          cond_true
);

  localparam int NLANE = 3;

  logic [DW-1:0] ln_res [NLANE];
  logic [NLANE-1:0] ln_n, ln_z, ln_v, ln_c;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    localparam int LW = DW >> (NLANE - 1 - g);
    logic [LW-1:0] lres;
    ccr_alu_lane #(.W(LW)) u_lane (
      .op   (op_code),
      .a    (opnd_a[LW-1:0]),
      .b    (opnd_b[LW-1:0]),
      .cin  (ccr_q[CCR_C]),
      .res  (lres),
      .fl_n (ln_n[g]),
      .fl_z (ln_z[g]),
      .fl_v (ln_v[g]),
      .fl_c (ln_c[g])
    );
    assign ln_res[g] = DW'(lres);
  end

  logic [1:0]    lane_idx;
  logic [DW-1:0] sel_res;
  logic          sel_n, sel_z, sel_v, sel_c;
  logic [7:0]    ccr_d;

  always_comb begin
    lane_idx = (op_size == 2'd3) ? 2'd2 : op_size;
    sel_res  = ln_res[lane_idx];
    sel_n    = ln_n[lane_idx];
    sel_z    = ln_z[lane_idx];
    sel_v    = ln_v[lane_idx];
    sel_c    = ln_c[lane_idx];
  end

  ccr_alu_flagmerge u_merge (
    .ccr_cur (ccr_q),
    .alu_go  (op_valid),
    .fclass  (op_class(op_code)),
    .fn      (sel_n),
    .fz      (sel_z),
    .fv      (sel_v),
    .fc      (sel_c),
    .wr_en   (ccr_wr_en),
    .wr_fn   (ccr_wr_fn),
    .imm     (ccr_imm),
    .ccr_nxt (ccr_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_q <= '0;
      ccr_q    <= CCR_RST;
    end else begin
      ccr_q <= ccr_d;
      if (op_valid && op_writes(op_code)) result_q <= sel_res;
    end
  end

  ccr_alu_cond u_cond (
    .flags (ccr_q[3:0]),
    .sel   (cond_sel),
    .take  (cond_true)
  );

endmodule

// File: rtl/ccr_alu_chk.sv
module ccr_alu_chk
  import ccr_alu_pkg::*;
#(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          op_valid,
  input logic [3:0]    op_code,
  input logic [1:0]    op_size,
  input logic          ccr_wr_en,
  input logic [1:0]    ccr_wr_fn,
  input logic [7:0]    ccr_imm,
  input logic [3:0]    cond_sel,
  input logic          cond_true,
  input logic [DW-1:0] result_q,
  input logic [7:0]    ccr_q
);

  p_cmp_keeps_result_r3: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OPC_CMP) |=> $stable(result_q));

  p_step_keeps_c_r5: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !ccr_wr_en && (op_code == OPC_INC || op_code == OPC_DEC))
      |=> ccr_q[CCR_C] == $past(ccr_q[CCR_C]));

  p_logic_clears_v_r6: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !ccr_wr_en && op_code >= OPC_AND && op_code <= OPC_MOV)
      |=> !ccr_q[CCR_V]);

  p_byte_upper_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_size == 2'd0 && op_code <= OPC_MOV && op_code != OPC_CMP)
      |=> result_q[DW-1:DW/4] == '0);

  p_long_nz_r7: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !ccr_wr_en && op_size[1] && op_code <= OPC_MOV && op_code != OPC_CMP)
      |=> (ccr_q[CCR_Z] == (result_q == '0)) && (ccr_q[CCR_N] == result_q[DW-1]));

  p_load_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (ccr_wr_en && ccr_wr_fn == CW_LOAD) |=> ccr_q == $past(ccr_imm));

  p_upper_kept_r9: assert property (@(posedge clk) disable iff (rst)
    !ccr_wr_en |=> ccr_q[7:4] == $past(ccr_q[7:4]));

  p_idle_ops_r10: assert property (@(posedge clk) disable iff (rst)
    (!ccr_wr_en && (!op_valid || op_code > OPC_MOV))
      |=> $stable(result_q) && $stable(ccr_q));

  p_always_never_r11: assert property (@(posedge clk) disable iff (rst)
    (cond_sel[3:1] == 3'd0) |-> (cond_true == !cond_sel[0]));

endmodule

bind ccr_alu ccr_alu_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .op_valid  (op_valid),
  .op_code   (op_code),
  .op_size   (op_size),
  .ccr_wr_en (ccr_wr_en),
  .ccr_wr_fn (ccr_wr_fn),
  .ccr_imm   (ccr_imm),
  .cond_sel  (cond_sel),
  .cond_true (cond_true),
  .result_q  (result_q),
  .ccr_q     (ccr_q)
);

// File: tb/sim_ccr_alu.sv
`timescale 1ns/1ps
module sim_ccr_alu;

  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          op_valid = 1'b0;
  logic [3:0]    op_code = '0;
  logic [1:0]    op_size = '0;
  logic [DW-1:0] opnd_a = '0;
  logic [DW-1:0] opnd_b = '0;
  logic          ccr_wr_en = 1'b0;
  logic [1:0]    ccr_wr_fn = '0;
  logic [7:0]    ccr_imm = '0;
  logic [3:0]    cond_sel = '0;
  logic [DW-1:0] result_q;
  logic [7:0]    ccr_q;
  logic          cond_true;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  ccr_alu #(.DW(DW)) u0 (.*);

  // entry: {req4, op4, size2, a32, b32, cin1, result32, nzvc4}
  localparam int NV = 25;
  localparam logic [110:0] VEC [NV] = '{
    {4'd2, 4'd0,  2'd0, 32'h0000007F, 32'h00000001, 1'b0, 32'h00000080, 4'b1010}, // R2
    {4'd2, 4'd0,  2'd0, 32'h000000FF, 32'h00000001, 1'b0, 32'h00000000, 4'b0101}, // R2
    {4'd2, 4'd0,  2'd1, 32'h00008000, 32'h00008000, 1'b0, 32'h00000000, 4'b0111}, // R2
    {4'd2, 4'd0,  2'd2, 32'hFFFFFFFF, 32'h00000002, 1'b0, 32'h00000001, 4'b0001}, // R2
    {4'd3, 4'd1,  2'd0, 32'h00000000, 32'h00000001, 1'b0, 32'h000000FF, 4'b1001}, // R3
    {4'd3, 4'd1,  2'd0, 32'h00000080, 32'h00000001, 1'b0, 32'h0000007F, 4'b0010}, // R3
    {4'd3, 4'd1,  2'd2, 32'h00000005, 32'h00000005, 1'b0, 32'h00000000, 4'b0100}, // R3
    {4'd3, 4'd1,  2'd1, 32'h00007FFF, 32'h0000FFFF, 1'b0, 32'h00008000, 4'b1011}, // R3
    {4'd4, 4'd3,  2'd0, 32'h00000080, 32'h00000000, 1'b0, 32'h00000080, 4'b1011}, // R4
    {4'd4, 4'd3,  2'd2, 32'h00000000, 32'h00000000, 1'b0, 32'h00000000, 4'b0100}, // R4
    {4'd4, 4'd3,  2'd1, 32'h00000001, 32'h00000000, 1'b0, 32'h0000FFFF, 4'b1001}, // R4
    {4'd2, 4'd4,  2'd0, 32'h0000000F, 32'h00000000, 1'b1, 32'h00000010, 4'b0000}, // R2
    {4'd2, 4'd4,  2'd1, 32'h0000FFFF, 32'h00000000, 1'b1, 32'h00000000, 4'b0101}, // R2
    {4'd3, 4'd5,  2'd0, 32'h00000010, 32'h0000000F, 1'b1, 32'h00000000, 4'b0100}, // R3
    {4'd3, 4'd5,  2'd2, 32'h00000000, 32'h00000000, 1'b1, 32'hFFFFFFFF, 4'b1001}, // R3
    {4'd5, 4'd6,  2'd0, 32'h0000007F, 32'h00000000, 1'b1, 32'h00000080, 4'b1011}, // R5
    {4'd5, 4'd6,  2'd0, 32'h000000FF, 32'h00000000, 1'b0, 32'h00000000, 4'b0100}, // R5
    {4'd5, 4'd7,  2'd1, 32'h00008000, 32'h00000000, 1'b0, 32'h00007FFF, 4'b0010}, // R5
    {4'd5, 4'd7,  2'd2, 32'h00000001, 32'h00000000, 1'b1, 32'h00000000, 4'b0101}, // R5
    {4'd6, 4'd8,  2'd1, 32'h0000F0F0, 32'h00000FF0, 1'b1, 32'h000000F0, 4'b0001}, // R6
    {4'd6, 4'd9,  2'd2, 32'h80000000, 32'h00000001, 1'b0, 32'h80000001, 4'b1000}, // R6
    {4'd6, 4'd10, 2'd0, 32'h000000AA, 32'h000000AA, 1'b1, 32'h00000000, 4'b0101}, // R6
    {4'd6, 4'd11, 2'd2, 32'h00001234, 32'h80000000, 1'b0, 32'h80000000, 4'b1000}, // R6
    {4'd7, 4'd11, 2'd0, 32'h00000000, 32'h123456F0, 1'b0, 32'h000000F0, 4'b1000}, // R7
    {4'd7, 4'd8,  2'd0, 32'hFFFFFF0F, 32'hFFFFFFFF, 1'b0, 32'h0000000F, 4'b0000}  // R7
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic [3:0] op, input logic [1:0] sz,
                       input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    op_valid = 1'b1; op_code = op; op_size = sz; opnd_a = a; opnd_b = b;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic do_ccr(input logic [1:0] fn, input logic [7:0] imm);
    @(negedge clk);
    ccr_wr_en = 1'b1; ccr_wr_fn = fn; ccr_imm = imm;
    @(negedge clk);
    ccr_wr_en = 1'b0;
  endtask

  function automatic logic cond_exp(input logic [3:0] s, input logic [3:0] f);
    logic n, z, v, c;
    n = f[3]; z = f[2]; v = f[1]; c = f[0];
    case (s)
      4'd0: return 1'b1;           4'd1: return 1'b0;
      4'd2: return !(c | z);       4'd3: return c | z;
      4'd4: return !c;             4'd5: return c;
      4'd6: return !z;             4'd7: return z;
      4'd8: return !v;             4'd9: return v;
      4'd10: return !n;            4'd11: return n;
      4'd12: return !(n ^ v);      4'd13: return n ^ v;
      4'd14: return !(z | (n ^ v));
      default: return z | (n ^ v);
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1 result", result_q, 32'h0);
    chk("R1 ccr", {24'h0, ccr_q}, 32'h80);

    // table walk: preset flags with upper nibble A and chosen carry
    for (int i = 0; i < NV; i++) begin
      logic [110:0] e;
      string tg;
      e = VEC[i];
      tg = $sformatf("R%0d entry %0d", e[110:107], i);
      do_ccr(2'd3, {4'hA, 3'b000, e[36]});
      do_op(e[106:103], e[102:101], e[100:69], e[68:37]);
      chk({tg, " result"}, result_q, e[35:4]);
      chk({tg, " flags"}, {24'h0, ccr_q}, {24'h0, 4'hA, e[3:0]});
    end

    // R3: compare keeps result, sets flags (5-7)
    do_op(4'd11, 2'd2, 32'h0, 32'h00000077);
    do_ccr(2'd3, 8'h00);
    do_op(4'd2, 2'd2, 32'h5, 32'h7);
    chk("R3 cmp result", result_q, 32'h77);
    chk("R3 cmp flags", {24'h0, ccr_q}, 32'h09);

    // R10: opcodes 12..15 change nothing
    do_ccr(2'd3, 8'h35);
    for (int k = 12; k < 16; k++) begin
      do_op(4'(k), 2'd2, 32'hFFFF0000, 32'h1);
      chk("R10 result", result_q, 32'h77);
      chk("R10 ccr", {24'h0, ccr_q}, 32'h35);
    end

    // R8: immediate functions
    do_ccr(2'd3, 8'h5A);
    chk("R8 load", {24'h0, ccr_q}, 32'h5A);
    do_ccr(2'd0, 8'h0F);
    chk("R8 and", {24'h0, ccr_q}, 32'h0A);
    do_ccr(2'd1, 8'h81);
    chk("R8 or", {24'h0, ccr_q}, 32'h8B);
    do_ccr(2'd2, 8'hFF);
    chk("R8 xor", {24'h0, ccr_q}, 32'h74);

    // R8: write wins over flags, result still written
    @(negedge clk);
    op_valid = 1'b1; op_code = 4'd0; op_size = 2'd0; opnd_a = 32'hFF; opnd_b = 32'h1;
    ccr_wr_en = 1'b1; ccr_wr_fn = 2'd3; ccr_imm = 8'h33;
    @(negedge clk);
    op_valid = 1'b0; ccr_wr_en = 1'b0;
    chk("R8 prio ccr", {24'h0, ccr_q}, 32'h33);
    chk("R8 prio result", result_q, 32'h0);

    // R6: logic clears a set V, keeps C
    do_ccr(2'd3, 8'h03);
    do_op(4'd9, 2'd0, 32'h1, 32'h0);
    chk("R6 v clear", {24'h0, ccr_q}, 32'h01);

    // R7: size code 3 acts as long
    do_ccr(2'd3, 8'h00);
    do_op(4'd0, 2'd3, 32'hFFFFFFFF, 32'h1);
    chk("R7 size3 result", result_q, 32'h0);
    chk("R7 size3 flags", {24'h0, ccr_q}, 32'h05);

    // R11: every condition under every flag pattern
    for (int f = 0; f < 16; f++) begin
      do_ccr(2'd3, {4'h0, 4'(f)});
      for (int s = 0; s < 16; s++) begin
        cond_sel = 4'(s);
        #1;
        chk($sformatf("R11 sel=%0d flags=%0h", s, f), {31'h0, cond_true},
            {31'h0, cond_exp(4'(s), 4'(f))});
      end
    end

    // R1: reset again after activity
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 re-reset result", result_q, 32'h0);
    chk("R1 re-reset ccr", {24'h0, ccr_q}, 32'h80);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule